// File: doc/BRIEF.md
# Write-Once Paged Data Memory

This block is a small synchronous data store in which every word carries its own occupancy flag. A store is accepted only when the target word is empty. If the word already holds a value, the store is refused, the old contents stay as they are, and a one-cycle error pulse is raised. A separate clear operation sets a word back to empty so that it can be written again. After reset, every word is empty.

Each access presents a 2-bit operation code, an address and write data. The address is treated as a page index and a row within the page. The number of pages is a parameter. A non-idle operation whose page index is out of range is rejected with the same error pulse and changes nothing. Read data is registered and appears one cycle after the read. Reading a word that is empty returns zero and pulses an empty-read flag.

Top module: `wom_paged_mem`

## Requirements
- R1: After synchronous reset, every word is empty, and `rd_data`, `empty_read` and `ovl_err` are all zero.
- R2: Operation codes are 2'b00 idle, 2'b01 clear, 2'b10 store and 2'b11 read. The page index is `addr / 8` (`addr[7:3]`) and the row is `addr % 8` (`addr[2:0]`), so words on different pages are independent.
- R3: A store to an empty, in-range word writes `wr_data` and marks the word occupied. A read issued in the next cycle returns that data.
- R4: A store to an occupied word leaves its contents unchanged. `ovl_err` is high for exactly the one cycle after that store.
- R5: After a valid read, `rd_data` shows the addressed word in the next cycle. At all other times, `rd_data` holds its last value.
- R6: A read of an empty in-range word gives `rd_data` = 0, and `empty_read` is high for the one cycle after the read.
- R7: A clear makes the addressed word empty without raising an error, including when the word is already empty. A later store to that word succeeds.
- R8: A non-idle operation whose page index is at or above `NUM_PAGES` (addresses 0x80 and above by default) pulses `ovl_err`. It changes no word, leaves `rd_data` as it was and does not pulse `empty_read`. It is never folded onto an in-range word.
- R9: An idle cycle changes no word and raises neither pulse, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 2 | Operation code: idle, clear, store, read |
| addr | input | 8 | Word address: page index and row |
| wr_data | input | 8 | Data for a store |
| rd_data | output | 8 | Registered read result |
| empty_read | output | 1 | Pulse: the last read found an empty word |
| ovl_err | output | 1 | Pulse: store to an occupied word, or page out of range |

## Verification
A wrong occupancy flag becomes visible at the ports on the next access to that word, one cycle after the access. A flag wrongly set gives a spurious `ovl_err` on a store, or stale data with no `empty_read` on a read. A flag wrongly cleared lets an overwrite through, and the next read then returns the new value. Wrong address splitting shows up as aliasing: a rejected store to address 0x80 followed by a read of address 0 exposes a word that is occupied by mistake. A clear that fails to take effect shows up on the next read as non-zero data.

// File: rtl/wom_pkg.sv
package wom_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_CLEAR = 2'b01,
    OP_STORE = 2'b10,
    OP_READ  = 2'b11
  } wom_op_e;
endpackage

// File: rtl/wom_addr_split.sv
module wom_addr_split #(
  parameter int ADDR_W    = 8,
  parameter int ROWS      = 8,
  parameter int NUM_PAGES = 16,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int PAGE_W = ADDR_W - ROW_W,
  localparam int DEPTH  = NUM_PAGES * ROWS,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PAGE_W-1:0] page,
  output logic [ROW_W-1:0]  row,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range
);
  // Rows per page must be a power of two so that the row is a bit field.
  initial begin
    if ((1 << ROW_W) != ROWS) $error("ROWS must be a power of two");
    if (NUM_PAGES > (1 << PAGE_W)) $error("NUM_PAGES exceeds address space");
  end

  assign row      = addr[ROW_W-1:0];
  assign page     = addr[ADDR_W-1:ROW_W];
  assign in_range = (int'(page) < NUM_PAGES);
  // The flat index is page * ROWS + row. It is meaningful only when in range.
  assign idx      = IDX_W'((int'(page) * ROWS) + int'(row));
endmodule

// File: rtl/wom_occ_flags.sv
module wom_occ_flags #(
  parameter int DEPTH = 128,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             set_en,
  input  logic             clr_en,
  output logic             occupied
);
  logic [DEPTH-1:0] flag;

  for (genvar w = 0; w < DEPTH; w++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        flag[w] <= 1'b0;
      end else if (int'(idx) == w) begin
        if (set_en)      flag[w] <= 1'b1;
        else if (clr_en) flag[w] <= 1'b0;
      end
    end
  end

  assign occupied = flag[idx];

  // R3: an accepted store leaves its word occupied.
  assert_store_marks_R3: assert property (@(posedge clk) disable iff (rst)
    set_en |=> flag[$past(idx)]);

  // R7: a clear leaves its word empty.
  assert_clear_frees_R7: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !flag[$past(idx)]);

  // R9/R8: with no enable, no flag moves.
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!set_en && !clr_en) |=> $stable(flag));
endmodule

// File: rtl/wom_data_array.sv
module wom_data_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  // Single-port array with a synchronous read register, so it maps to block RAM.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) q <= mem[idx];
  end
endmodule

// File: rtl/wom_paged_mem.sv
module wom_paged_mem
  import wom_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int ROWS      = 8,
  parameter int NUM_PAGES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty_read,
  output logic              ovl_err
);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int PAGE_W = ADDR_W - ROW_W;
  localparam int DEPTH  = NUM_PAGES * ROWS;
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  wom_op_e           op_e;
  logic [PAGE_W-1:0] page;
  logic [ROW_W-1:0]  row;
  logic [IDX_W-1:0]  idx;
  logic              in_range;
  logic              occupied;
  logic              store_ok, clear_ok, read_ok, reject;
  logic [DATA_W-1:0] arr_q;
  logic              hit_q;

  assign op_e = wom_op_e'(op);

  wom_addr_split #(.ADDR_W(ADDR_W), .ROWS(ROWS), .NUM_PAGES(NUM_PAGES)) u_split (
    .addr(addr), .page(page), .row(row), .idx(idx), .in_range(in_range)
  );

  assign store_ok = (op_e == OP_STORE) && in_range && !occupied;
  assign clear_ok = (op_e == OP_CLEAR) && in_range;
  assign read_ok  = (op_e == OP_READ)  && in_range;
  assign reject   = ((op_e != OP_IDLE) && !in_range) ||
                    ((op_e == OP_STORE) && in_range && occupied);

  wom_occ_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .idx(idx),
    .set_en(store_ok), .clr_en(clear_ok), .occupied(occupied)
  );

  wom_data_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
    .clk(clk), .we(store_ok), .re(read_ok), .idx(idx), .wdata(wr_data), .q(arr_q)
  );

  // Occupancy captured with the read. Empty words read back as zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q      <= 1'b0;
      empty_read <= 1'b0;
      ovl_err    <= 1'b0;
    end else begin
      if (read_ok) hit_q <= occupied;
      empty_read <= read_ok && !occupied;
      ovl_err    <= reject;
    end
  end

  assign rd_data = hit_q ? arr_q : '0;

  // R4/R8: an error pulse always follows a non-idle operation.
  assert_err_cause_R4: assert property (@(posedge clk) disable iff (rst)
    ovl_err |-> ($past(op) != OP_IDLE));

  // R9: an idle cycle is never followed by a pulse.
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_IDLE) |=> (!ovl_err && !empty_read));

  // R6: an empty-read pulse comes with zero data after a read.
  assert_empty_zero_R6: assert property (@(posedge clk) disable iff (rst)
    empty_read |-> (rd_data == '0 && $past(op) == OP_READ));

  // R5: without a valid read, the read result does not move.
  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !read_ok |=> $stable(rd_data));

  // R8: an out-of-range access never yields an empty-read pulse.
  assert_oor_no_empty_R8: assert property (@(posedge clk) disable iff (rst)
    !in_range |=> !empty_read);
endmodule

// File: tb/wom_paged_mem_bench.sv
module wom_paged_mem_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op = 2'b00;
  logic [7:0] addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       empty_read;
  logic       ovl_err;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  wom_paged_mem u_wom_paged_mem (
    .clk(clk), .rst(rst), .op(op), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .empty_read(empty_read), .ovl_err(ovl_err)
  );

  // Vector fields: op, addr, wr_data, expected rd_data, expected empty_read,
  // expected ovl_err.
  localparam int NV = 23;
  localparam logic [27:0] VEC [NV] = '{
    {2'b11, 8'h05, 8'h00, 8'h00, 1'b1, 1'b0}, // R6 read of empty word
    {2'b10, 8'h05, 8'hA5, 8'h00, 1'b0, 1'b0}, // R3 store to empty word
    {2'b11, 8'h05, 8'h00, 8'hA5, 1'b0, 1'b0}, // R3 R5 read back
    {2'b10, 8'h05, 8'h3C, 8'hA5, 1'b0, 1'b1}, // R4 overwrite refused
    {2'b11, 8'h05, 8'h00, 8'hA5, 1'b0, 1'b0}, // R4 contents kept, pulse gone
    {2'b00, 8'h05, 8'h99, 8'hA5, 1'b0, 1'b0}, // R9 idle
    {2'b10, 8'h0D, 8'h77, 8'hA5, 1'b0, 1'b0}, // R2 page 1 row 5
    {2'b11, 8'h0D, 8'h00, 8'h77, 1'b0, 1'b0}, // R2 read other page
    {2'b11, 8'h05, 8'h00, 8'hA5, 1'b0, 1'b0}, // R2 page 0 intact
    {2'b01, 8'h05, 8'h00, 8'hA5, 1'b0, 1'b0}, // R7 clear occupied
    {2'b11, 8'h05, 8'h00, 8'h00, 1'b1, 1'b0}, // R7 now empty
    {2'b01, 8'h05, 8'h00, 8'h00, 1'b0, 1'b0}, // R7 clear empty, no error
    {2'b10, 8'h05, 8'h5A, 8'h00, 1'b0, 1'b0}, // R7 store after clear
    {2'b11, 8'h05, 8'h00, 8'h5A, 1'b0, 1'b0}, // R7 new data
    {2'b10, 8'h90, 8'h11, 8'h5A, 1'b0, 1'b1}, // R8 store out of range
    {2'b11, 8'h90, 8'h00, 8'h5A, 1'b0, 1'b1}, // R8 read out of range
    {2'b01, 8'h85, 8'h00, 8'h5A, 1'b0, 1'b1}, // R8 clear out of range
    {2'b00, 8'hFF, 8'h00, 8'h5A, 1'b0, 1'b0}, // R9 idle out of range
    {2'b10, 8'h7F, 8'hEE, 8'h5A, 1'b0, 1'b0}, // R8 last valid word
    {2'b11, 8'h7F, 8'h00, 8'hEE, 1'b0, 1'b0}, // R8 last valid read
    {2'b11, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0}, // R2 word 0 empty
    {2'b10, 8'h80, 8'h22, 8'h00, 1'b0, 1'b1}, // R8 first invalid page
    {2'b11, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0}  // R8 no alias onto word 0
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] o, input logic [7:0] a, input logic [7:0] d);
    op = o; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "rd_data", rd_data, 8'h00);
    check("R1", "empty_read", {7'b0, empty_read}, 8'h00);
    check("R1", "ovl_err", {7'b0, ovl_err}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("vector%0d", i);
      step(v[27:26], v[25:18], v[17:10]);
      check(tag, "rd_data", rd_data, v[9:2]);
      check(tag, "empty_read", {7'b0, empty_read}, {7'b0, v[1]});
      check(tag, "ovl_err", {7'b0, ovl_err}, {7'b0, v[0]});
    end

    // R4 error pulse lasts one cycle only
    step(2'b10, 8'h7F, 8'h01);
    check("R4", "ovl_err", {7'b0, ovl_err}, 8'h01);
    step(2'b00, 8'h00, 8'h00);
    check("R4", "ovl_err", {7'b0, ovl_err}, 8'h00);

    // R1 mid-run reset empties every word
    rst = 1'b1;
    step(2'b00, 8'h00, 8'h00);
    rst = 1'b0;
    check("R1", "rd_data", rd_data, 8'h00);
    step(2'b11, 8'h0D, 8'h00);
    check("R1", "rd_data", rd_data, 8'h00);
    check("R1", "empty_read", {7'b0, empty_read}, 8'h01);
    step(2'b10, 8'h7F, 8'h42);
    check("R1", "ovl_err", {7'b0, ovl_err}, 8'h00);
    step(2'b11, 8'h7F, 8'h00);
    check("R3", "rd_data", rd_data, 8'h42);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule